// File: doc/BRIEF.md
# Latency-Insensitive Register Node

This block places a clocked register, or a chain of two registers, between two bounded FIFOs that belong to the surrounding dataflow network. The node reads tokens from an upstream FIFO read port, which offers an availability flag, the head value and a take strobe. It writes tokens into a downstream FIFO write port, which offers a room flag, a put strobe and the data. Each token written downstream carries the register contents as they stood before the matching upstream token was absorbed. The first output therefore comes straight from the reset value and needs no input.

A one-bit phase flag orders the two actions. The node first emits its current tail value as soon as the downstream FIFO has room. It then waits in the absorb phase until an input token is available, shifts that token into the chain and returns to the emit phase. Because output never waits on input, the node does not deadlock when its output FIFO is wired back to its own input. Because every emit is followed by exactly one absorb, it also does not deadlock with depth-1 FIFOs.

Top module: `li_reg_node`

## Requirements
- R1: After reset the node is in the emit phase and `snk_data` shows `TAIL_INIT`. No input is taken before the first output. The first put needs only `snk_room`, even when no input is available.
- R2: `snk_put` is high exactly when the node is in the emit phase and `snk_room` is high. It is never high without `snk_room`.
- R3: Puts and takes strictly alternate, starting with a put. After a put, no other put occurs until one take has happened. After a take, no other take occurs until one put has happened.
- R4: `src_take` is high exactly when the node is in the absorb phase and `src_avail` is high. It is never high without `src_avail`.
- R5: `snk_put` and `src_take` are never high in the same cycle.
- R6: With `STAGES`=1, output token n equals `TAIL_INIT` for n=0 and equals input token n-1 for n>0.
- R7: With `STAGES`=2, output token 0 equals `TAIL_INIT`, output token 1 equals `HEAD_INIT`, and output token n equals input token n-2 for n>=2.
- R8: `src_data` is ignored in any cycle without a take. `snk_data` changes only in the cycle after a take.
- R9: With `snk_put` feeding a depth-1 FIFO whose output returns to the node's input, the node keeps running. It produces one token every two cycles, and every token equals `TAIL_INIT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_avail | input | 1 | Upstream FIFO not empty |
| src_data | input | W | Upstream FIFO head value |
| src_take | output | 1 | Dequeue strobe to the upstream FIFO |
| snk_room | input | 1 | Downstream FIFO not full |
| snk_put | output | 1 | Enqueue strobe to the downstream FIFO |
| snk_data | output | W | Token value written downstream (tail stage) |

## Verification
The assertions assume the FIFOs around the node behave honestly. The availability and room flags may change freely from cycle to cycle. `src_data` is only meaningful while `src_avail` is high. The stimulus holds to this: it drives the flags from a pseudo-random sequence with stretches of full throughput and heavy backpressure. It presents the next numbered token whenever availability is high and deliberately corrupt data whenever it is low. A loop instance closes the output onto its input through a modelled depth-1 FIFO, whose flags are derived only from its own occupancy.

// File: rtl/li_node_pkg.sv
`timescale 1ns/1ps
package li_node_pkg;

  typedef enum logic {
    PH_EMIT   = 1'b0,
    PH_ABSORB = 1'b1
  } node_phase_e;

  // emit fires when the current token is not yet sent and the sink has room
  function automatic logic emit_fires(node_phase_e ph, logic room);
    return (ph == PH_EMIT) && room;
  endfunction

  // absorb fires once the token is out and the source holds data
  function automatic logic absorb_fires(node_phase_e ph, logic avail);
    return (ph == PH_ABSORB) && avail;
  endfunction

  function automatic node_phase_e phase_step(node_phase_e ph, logic emit, logic absorb);
    node_phase_e nxt;
    nxt = ph;
    if (emit)   nxt = PH_ABSORB;
    if (absorb) nxt = PH_EMIT;
    return nxt;
  endfunction

endpackage

// File: rtl/li_node_ctrl.sv
`timescale 1ns/1ps
module li_node_ctrl
  import li_node_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic room,
  input  logic avail,
  output logic emit,
  output logic absorb
);

  node_phase_e phase_q;

  always_comb begin
    emit   = emit_fires(phase_q, room);
    absorb = absorb_fires(phase_q, avail);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_EMIT;
    else        phase_q <= phase_step(phase_q, emit, absorb);
  end

endmodule

// File: rtl/li_node_chain.sv
`timescale 1ns/1ps
module li_node_chain #(
  parameter int              W         = 8,
  parameter int              STAGES    = 1,
  parameter logic [W-1:0]    HEAD_INIT = '0,
  parameter logic [W-1:0]    TAIL_INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  localparam int LAST = STAGES - 1;

  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    localparam logic [W-1:0] INIT = (s == LAST) ? TAIL_INIT : HEAD_INIT;
    logic [W-1:0] feed;
    if (s == 0) begin : g_head
      assign feed = din;
    end else begin : g_link
      assign feed = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    stage_q[s] <= INIT;
      else if (load) stage_q[s] <= feed;
    end
  end

  assign dout = stage_q[LAST];

endmodule

// File: rtl/li_reg_node.sv
`timescale 1ns/1ps
module li_reg_node #(
  parameter int           W         = 8,
  parameter int           STAGES    = 1,
  parameter logic [W-1:0] HEAD_INIT = '0,
  parameter logic [W-1:0] TAIL_INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         src_avail,
  input  logic [W-1:0] src_data,
  output logic         src_take,
  input  logic         snk_room,
  output logic         snk_put,
  output logic [W-1:0] snk_data
);

  logic ev_emit;
  logic ev_absorb;

  li_node_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .room   (snk_room),
    .avail  (src_avail),
    .emit   (ev_emit),
    .absorb (ev_absorb)
  );

  li_node_chain #(
    .W         (W),
    .STAGES    (STAGES),
    .HEAD_INIT (HEAD_INIT),
    .TAIL_INIT (TAIL_INIT)
  ) u_chain (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (ev_absorb),
    .din   (src_data),
    .dout  (snk_data)
  );

  assign snk_put  = ev_emit;
  assign src_take = ev_absorb;

endmodule

// File: rtl/li_reg_node_chk.sv
`timescale 1ns/1ps
module li_reg_node_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         src_avail,
  input logic         src_take,
  input logic         snk_room,
  input logic         snk_put,
  input logic [W-1:0] snk_data
);

  logic started_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started_q <= 1'b0;
    else        started_q <= 1'b1;
  end

  AST_NO_TAKE_FIRST: assert property (@(posedge clk) disable iff (!rst_n) !started_q |-> !src_take); // R1
  AST_PUT_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n) snk_put |-> snk_room); // R2
  AST_NO_DOUBLE_PUT: assert property (@(posedge clk) disable iff (!rst_n) snk_put |=> !snk_put); // R3
  AST_NO_DOUBLE_TAKE: assert property (@(posedge clk) disable iff (!rst_n) src_take |=> !src_take); // R3
  AST_TAKE_NEEDS_AVAIL: assert property (@(posedge clk) disable iff (!rst_n) src_take |-> src_avail); // R4
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n) !(snk_put && src_take)); // R5
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (started_q && !$past(src_take)) |-> $stable(snk_data)); // R8

endmodule

bind li_reg_node li_reg_node_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_avail (src_avail),
  .src_take  (src_take),
  .snk_room  (snk_room),
  .snk_put   (snk_put),
  .snk_data  (snk_data)
);

// File: tb/sim_li_reg_node.sv
`timescale 1ns/1ps
module sim_li_reg_node;

  localparam int W = 8;
  localparam logic [W-1:0] A_TAIL = 8'hA5;
  localparam logic [W-1:0] B_HEAD = 8'h3C;
  localparam logic [W-1:0] B_TAIL = 8'hC3;
  localparam logic [W-1:0] L_TAIL = 8'h5A;
  localparam int CYCLES = 4000;

  logic clk = 1'b0;
  always #10 clk = ~clk;
  logic rst_n;

  logic a_avail, a_take, a_room, a_put; logic [W-1:0] a_data, a_out;
  logic b_avail, b_take, b_room, b_put; logic [W-1:0] b_data, b_out;
  logic l_avail, l_take, l_room, l_put; logic [W-1:0] l_data, l_out;

  li_reg_node #(.W(W), .STAGES(1), .HEAD_INIT(8'h00), .TAIL_INIT(A_TAIL)) u0 (
    .clk(clk), .rst_n(rst_n), .src_avail(a_avail), .src_data(a_data), .src_take(a_take),
    .snk_room(a_room), .snk_put(a_put), .snk_data(a_out));
  li_reg_node #(.W(W), .STAGES(2), .HEAD_INIT(B_HEAD), .TAIL_INIT(B_TAIL)) u1 (
    .clk(clk), .rst_n(rst_n), .src_avail(b_avail), .src_data(b_data), .src_take(b_take),
    .snk_room(b_room), .snk_put(b_put), .snk_data(b_out));
  li_reg_node #(.W(W), .STAGES(1), .HEAD_INIT(8'h00), .TAIL_INIT(L_TAIL)) u2 (
    .clk(clk), .rst_n(rst_n), .src_avail(l_avail), .src_data(l_data), .src_take(l_take),
    .snk_room(l_room), .snk_put(l_put), .snk_data(l_out));

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  function automatic logic [W-1:0] tok(int i);
    return W'(i * 37 + 11);
  endfunction

  task automatic chk(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    int a_puts = 0, a_takes = 0, b_puts = 0, b_takes = 0, l_puts = 0;
    bit l_full = 0, l_set = 0, l_clr = 0;
    logic [W-1:0] l_q = '0, l_in = '0, a_prev = '0;
    bit a_prev_take = 0;
    logic [15:0] lfsr = 16'hACE1;
    rst_n = 0;
    {a_avail, a_room, b_avail, b_room} = '0;
    a_data = '0; b_data = '0;
    l_avail = 0; l_room = 0; l_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int cyc = 0; cyc < CYCLES; cyc++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (l_set) begin l_full = 1; l_q = l_in; end
      if (l_clr) l_full = 0;
      l_set = 0; l_clr = 0;
      if (cyc < 3) begin
        a_room = 0; a_avail = 1;
      end else if (cyc >= 1000 && cyc < 1400) begin
        a_room = 1; a_avail = 1;
      end else if (cyc >= 2000 && cyc < 2400) begin
        a_room = lfsr[0] & lfsr[1]; a_avail = lfsr[2] & lfsr[6];
      end else begin
        a_room = lfsr[0] | lfsr[1]; a_avail = lfsr[2] | lfsr[5];
      end
      a_data = a_avail ? tok(a_takes) : ~tok(a_takes) ^ lfsr[7:0];
      b_room = lfsr[3] | lfsr[8];
      b_avail = lfsr[4] | lfsr[9];
      b_data = b_avail ? tok(b_takes) : ~tok(b_takes) ^ lfsr[15:8];
      l_room = !l_full; l_avail = l_full; l_data = l_q;
      #1;
      if (cyc < 3) begin
        chk(!a_take, "R1 no take before first put", {7'd0, a_take}, 8'd0);
        chk(a_out == A_TAIL, "R1 reset tail value", a_out, A_TAIL);
      end
      // instance u0: single stage
      chk(!(a_put && a_take), "R5 u0 put and take together", {7'd0, a_put}, 8'd0);
      chk(a_put == (a_room && a_puts == a_takes), "R2 u0 put rule", {7'd0, a_put},
          {7'd0, (a_room && a_puts == a_takes)});
      chk(a_take == (a_avail && a_puts == a_takes + 1), "R4 u0 take rule", {7'd0, a_take},
          {7'd0, (a_avail && a_puts == a_takes + 1)});
      if (cyc > 0 && !a_prev_take)
        chk(a_out == a_prev, "R8 u0 data held without take", a_out, a_prev);
      if (a_put) begin
        chk(a_puts == a_takes, "R3 u0 alternation on put", 8'(a_puts), 8'(a_takes));
        chk(a_out == ((a_puts == 0) ? A_TAIL : tok(a_puts - 1)), "R6 u0 token value", a_out,
            (a_puts == 0) ? A_TAIL : tok(a_puts - 1));
        a_puts++;
      end
      if (a_take) a_takes++;
      a_prev = a_out; a_prev_take = a_take;
      // instance u1: two stages
      chk(!(b_put && b_take), "R5 u1 put and take together", {7'd0, b_put}, 8'd0);
      if (b_put) begin
        logic [W-1:0] e;
        e = (b_puts == 0) ? B_TAIL : (b_puts == 1) ? B_HEAD : tok(b_puts - 2);
        chk(b_puts == b_takes, "R3 u1 alternation on put", 8'(b_puts), 8'(b_takes));
        chk(b_out == e, "R7 u1 token value", b_out, e);
        b_puts++;
      end
      if (b_take) begin
        chk(b_takes + 1 == b_puts, "R3 u1 alternation on take", 8'(b_takes + 1), 8'(b_puts));
        b_takes++;
      end
      // instance u2: output looped through a depth-1 FIFO
      if (l_put) begin
        chk(l_out == L_TAIL, "R9 loop token value", l_out, L_TAIL);
        l_puts++; l_set = 1; l_in = l_out;
      end
      if (l_take) l_clr = 1;
    end
    chk(a_puts > 300, "R6 u0 progress", 8'(a_puts > 300), 8'd1);
    chk(b_puts > 300, "R7 u1 progress", 8'(b_puts > 300), 8'd1);
    chk(l_puts >= 1900, "R9 loop progress", 8'(l_puts >= 1900), 8'd1);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule